// File: doc/BRIEF.md
# Debug Breakpoint Control Unit

This unit sits next to a CPU core and decides when the core has to stop for a debugger. It holds one 8-bit control register and four 24-bit match registers. A plain register-write port loads all of them. Each cycle the unit looks at the core's instruction-fetch address and at a qualifier that is high only for the first opcode byte of an instruction. When an enabled comparator matches on a qualified fetch, the unit raises its break output and holds it until the debugger releases it.

The break output is the stored break flag, bit 7 of the control register. The debugger can set this flag to force a halt and clear it to let the core run again. A comparator match sets the same flag in hardware. Comparator 1 has an option that ignores the low address byte, so it matches anywhere in a 256-byte page.

The unit also reads two debug pin levels while reset is held. If the pins show the right pattern on the last reset cycle, the core halts on its first instruction. A match-status field records which comparators caused the most recent break, so the debugger can read it back.

Top module: `dbg_break_unit`

## Requirements
- R1: During reset (rstN low, synchronous) the control register and the hit mask clear to 0 and every match register clears to 0. The one exception is control bit 7, which R2 sets.
- R2: On each reset cycle, control bit 7 is loaded with (dbgClkPin AND NOT dbgDataPin). After reset, brkOut is therefore 1 only if the last reset cycle saw the clock pin high and the data pin low.
- R3: A write to register address 0x10 loads control bits 7..2 from regWrData[7:2]. Writing 1 to bit 7 forces brkOut high on the next cycle. Writing 0 to bit 7 drops brkOut on the next cycle, and any control write clears hitMask.
- R4: Control bits 1..0 are reserved. They always read 0 on ctrlOut, whatever value was written.
- R5: Control bits 6, 5, 4 and 3 enable comparators 3, 2, 1 and 0 in that order. A comparator whose enable bit is 0 never causes a break.
- R6: Comparator n's register is written at address 4n+b, where b=0 is the low byte, b=1 the high byte and b=2 the upper byte (address bits 23:16). Without masking, a comparator matches only when all 24 fetch-address bits equal its register.
- R7: Control bit 2 makes comparator 1 compare only address bits 23:8, so it matches anywhere in a 256-byte page. The bit has no effect on comparators 0, 2 and 3.
- R8: A match is evaluated only in a cycle where fetchFirst is 1. An address on a non-first byte never triggers a break.
- R9: A qualified match sets control bit 7 at the next clock edge. brkOut is high in the cycle after the matching fetch, so the halt is in place before that instruction executes.
- R10: When several enabled comparators match in the same cycle, they cause one break. hitMask (bit n for comparator n) records every comparator that hit.
- R11: While brkOut is 1, fetches are not evaluated. hitMask and brkOut stay unchanged until a control write occurs.
- R12: If a qualified match and a control write with bit 7 = 0 fall in the same cycle, the match wins. brkOut stays or becomes 1, and hitMask takes the new hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dbgClkPin | input | 1 | Debug clock pin level, sampled during reset |
| dbgDataPin | input | 1 | Debug data pin level, sampled during reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address (0x10 control, 4n+b match bytes) |
| regWrData | input | 8 | Register write data |
| fetchAddr | input | 24 | CPU instruction-fetch address |
| fetchFirst | input | 1 | High when fetchAddr is the first opcode byte |
| brkOut | output | 1 | Halt request to the CPU (control bit 7) |
| ctrlOut | output | 8 | Control register readback |
| hitMask | output | 4 | Comparators that caused the last break |

## Verification
All three outputs are registered. A register write, a qualified fetch or a reset cycle shows its effect exactly one clock edge after it is driven. The pin pattern shows up as soon as the first reset edge has passed. The driver applies each stimulus on a falling edge and waits for the next rising edge. It then queues the expected brkOut, ctrlOut and hitMask values, and the monitor compares them on the following falling edge, exactly one edge later. Match-register writes land in the same edge, so any comparison in that cycle still uses the old register value, and the expected values follow that rule.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;
  localparam int NUM_COMP  = 4;
  localparam int ADDR_W    = 24;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = ADDR_W / BYTE_W;
  localparam int SEL_W     = $clog2(NUM_BYTES);
  localparam int REG_AW    = 5;
  localparam int CTRL_W    = 8;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 5'h10;
  localparam int BRK_BIT   = 7;
  localparam int ENA_LSB   = 3;
  localparam int IGN_BIT   = 2;
  localparam int MASK_COMP = 1;
  localparam logic [CTRL_W-1:0] WR_MASK = 8'hFC;

  typedef struct packed {
    logic [NUM_COMP-1:0] compWr;
    logic [SEL_W-1:0]    byteSel;
    logic [BYTE_W-1:0]   wrByte;
    logic [NUM_COMP-1:0] compEn;
    logic                ignLow;
  } dpStrobe_t;
endpackage

// File: rtl/dbg_break_dp.sv
module dbg_break_dp
  import dbg_break_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [ADDR_W-1:0]   fetchAddr,
  output logic [NUM_COMP-1:0] compHit
);
  localparam int PAGE_LSB = BYTE_W;

  for (genvar i = 0; i < NUM_COMP; i++) begin : gComp
    logic [ADDR_W-1:0] matchReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchReg <= '0;
      end else if (strb.compWr[i]) begin
        for (int b = 0; b < NUM_BYTES; b++) begin
          if (strb.byteSel == SEL_W'(b)) matchReg[b*BYTE_W +: BYTE_W] <= strb.wrByte;
        end
      end
    end

    if (i == MASK_COMP) begin : gPageMask
      logic upperEq;
      assign upperEq    = fetchAddr[ADDR_W-1:PAGE_LSB] == matchReg[ADDR_W-1:PAGE_LSB];
      assign compHit[i] = strb.compEn[i] && upperEq &&
                          (strb.ignLow || fetchAddr[PAGE_LSB-1:0] == matchReg[PAGE_LSB-1:0]);
    end else begin : gFull
      assign compHit[i] = strb.compEn[i] && (fetchAddr == matchReg);
    end
  end
endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
  import dbg_break_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                dbgClkPin,
  input  logic                dbgDataPin,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic                fetchFirst,
  input  logic [NUM_COMP-1:0] compHit,
  output dpStrobe_t           strb,
  output logic [CTRL_W-1:0]   ctrlReg,
  output logic [NUM_COMP-1:0] hitMask
);
  logic ctrlWr;
  logic evalEn;
  logic trigger;
  logic resetBrk;

  assign ctrlWr   = regWrEn && (regAddr == CTRL_ADDR);
  assign evalEn   = fetchFirst && !ctrlReg[BRK_BIT];
  assign trigger  = evalEn && (|compHit);
  assign resetBrk = dbgClkPin && !dbgDataPin;

  always_comb begin
    strb         = '0;
    strb.byteSel = regAddr[SEL_W-1:0];
    strb.wrByte  = regWrData;
    strb.compEn  = ctrlReg[ENA_LSB +: NUM_COMP];
    strb.ignLow  = ctrlReg[IGN_BIT];
    for (int i = 0; i < NUM_COMP; i++) begin
      strb.compWr[i] = regWrEn && !regAddr[REG_AW-1] &&
                       (regAddr[REG_AW-2:SEL_W] == (REG_AW-1-SEL_W)'(i)) &&
                       (int'(regAddr[SEL_W-1:0]) < NUM_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg          <= '0;
      ctrlReg[BRK_BIT] <= resetBrk;
      hitMask          <= '0;
    end else begin
      if (ctrlWr) begin
        ctrlReg <= regWrData & WR_MASK;
        hitMask <= '0;
      end
      if (trigger) begin
        ctrlReg[BRK_BIT] <= 1'b1;
        hitMask          <= compHit;
      end
    end
  end
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
  import dbg_break_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                dbgClkPin,
  input  logic                dbgDataPin,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [BYTE_W-1:0]   regWrData,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                fetchFirst,
  output logic                brkOut,
  output logic [CTRL_W-1:0]   ctrlOut,
  output logic [NUM_COMP-1:0] hitMask
);
  dpStrobe_t           strb;
  logic [NUM_COMP-1:0] compHit;
  logic [CTRL_W-1:0]   ctrlReg;

  dbg_break_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .dbgClkPin(dbgClkPin), .dbgDataPin(dbgDataPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .fetchFirst(fetchFirst), .compHit(compHit), .strb(strb),
    .ctrlReg(ctrlReg), .hitMask(hitMask)
  );

  dbg_break_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchAddr(fetchAddr), .compHit(compHit)
  );

  assign brkOut  = ctrlReg[BRK_BIT];
  assign ctrlOut = ctrlReg;
endmodule

// File: rtl/dbg_break_chk.sv
module dbg_break_chk
  import dbg_break_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic [BYTE_W-1:0]   regWrData,
  input logic                fetchFirst,
  input logic [NUM_COMP-1:0] compHit,
  input logic                brkOut,
  input logic [CTRL_W-1:0]   ctrlOut,
  input logic [NUM_COMP-1:0] hitMask
);
  logic ctrlWrSeen;
  assign ctrlWrSeen = regWrEn && (regAddr == CTRL_ADDR);

  // R3 R9
  brk_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(brkOut)) |->
      $past((ctrlWrSeen && regWrData[BRK_BIT]) || (fetchFirst && |compHit)));

  // R3
  brk_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(brkOut)) |-> $past(ctrlWrSeen && !regWrData[BRK_BIT]));

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut[1:0] == 2'b00);

  // R10
  hit_implies_brk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitMask != '0) |-> brkOut);

  // R8
  first_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!fetchFirst && !ctrlWrSeen)) |->
      ($stable(brkOut) && $stable(hitMask)));

  // R11
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(brkOut && !ctrlWrSeen)) |-> (brkOut && $stable(hitMask)));
endmodule

bind dbg_break_unit dbg_break_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .fetchFirst(fetchFirst), .compHit(compHit),
  .brkOut(brkOut), .ctrlOut(ctrlOut), .hitMask(hitMask)
);

// File: tb/dbg_break_unit_tb_top.sv
module dbg_break_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgClkPin = 1'b0;
  logic        dbgDataPin = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [23:0] fetchAddr = '0;
  logic        fetchFirst = 1'b0;
  logic        brkOut;
  logic [7:0]  ctrlOut;
  logic [3:0]  hitMask;

  always #5 clk = ~clk;

  dbg_break_unit dut_i (
    .clk(clk), .rstN(rstN), .dbgClkPin(dbgClkPin), .dbgDataPin(dbgDataPin),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .fetchAddr(fetchAddr), .fetchFirst(fetchFirst),
    .brkOut(brkOut), .ctrlOut(ctrlOut), .hitMask(hitMask)
  );

  typedef struct {
    string      tag;
    logic       brk;
    logic [7:0] ctrl;
    logic [3:0] hit;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [7:0]  mCtrl = '0;
  logic [3:0]  mHit = '0;
  logic [23:0] mComp [4];

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (brkOut !== e.brk || ctrlOut !== e.ctrl || hitMask !== e.hit) begin
        errors++;
        $display("FAIL %s: brk/ctrl/hit got %b/%h/%b expected %b/%h/%b",
                 e.tag, brkOut, ctrlOut, hitMask, e.brk, e.ctrl, e.hit);
      end
    end
  end

  task automatic pushExp(string tag);
    exp_t e;
    e.tag  = tag;
    e.brk  = mCtrl[7];
    e.ctrl = mCtrl;
    e.hit  = mHit;
    expQ.push_back(e);
  endtask

  task automatic doReset(bit c, bit d, string tag);
    @(negedge clk);
    rstN = 1'b0; dbgClkPin = c; dbgDataPin = d; regWrEn = 1'b0; fetchFirst = 1'b0;
    repeat (2) @(posedge clk);
    mCtrl = {c & ~d, 7'b0};
    mHit  = '0;
    for (int k = 0; k < 4; k++) mComp[k] = '0;
    #1 pushExp(tag);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step(bit wr, logic [4:0] a, logic [7:0] d, logic [23:0] fa, bit ff, string tag);
    logic [3:0] hits;
    logic       trig;
    logic [7:0] nC;
    logic [3:0] nH;
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; fetchAddr = fa; fetchFirst = ff;
    for (int k = 0; k < 4; k++) begin
      if (k == 1 && mCtrl[2]) hits[k] = mCtrl[3+k] && (fa[23:8] == mComp[k][23:8]);
      else                    hits[k] = mCtrl[3+k] && (fa == mComp[k]);
    end
    trig = ff && !mCtrl[7] && (|hits);
    nC = mCtrl;
    nH = mHit;
    if (wr && a == 5'h10) begin nC = d & 8'hFC; nH = '0; end
    if (trig) begin nC[7] = 1'b1; nH = hits; end
    if (wr && !a[4] && a[1:0] != 2'd3) mComp[a[3:2]][a[1:0]*8 +: 8] = d;
    @(posedge clk);
    mCtrl = nC;
    mHit  = nH;
    #1 pushExp(tag);
  endtask

  task automatic wrReg(logic [4:0] a, logic [7:0] d, string tag);
    step(1'b1, a, d, 24'h0, 1'b0, tag);
  endtask

  task automatic fetch(logic [23:0] fa, bit ff, string tag);
    step(1'b0, 5'h0, 8'h0, fa, ff, tag);
  endtask

  initial begin
    doReset(1'b0, 1'b0, "R1 reset state");
    fetch(24'h0, 1'b0, "R1 idle after reset");
    doReset(1'b1, 1'b1, "R2 both pins high no break");
    doReset(1'b0, 1'b1, "R2 data high no break");
    doReset(1'b1, 1'b0, "R2 break at reset");
    fetch(24'h0, 1'b0, "R2 break held");
    wrReg(5'h10, 8'h00, "R3 release");
    wrReg(5'h10, 8'h80, "R3 forced break");
    wrReg(5'h10, 8'h00, "R3 release again");
    wrReg(5'h10, 8'hFF, "R4 reserved bits read zero");
    wrReg(5'h10, 8'h00, "R4 clear");
    // comparator programming (R6 layout)
    wrReg(5'd0, 8'h56, "R6 c0 low");  wrReg(5'd1, 8'h34, "R6 c0 high");  wrReg(5'd2, 8'h12, "R6 c0 upper");
    wrReg(5'd3, 8'hEE, "R6 unused slot");
    wrReg(5'd4, 8'h12, "R6 c1 low");  wrReg(5'd5, 8'hCD, "R6 c1 high");  wrReg(5'd6, 8'hAB, "R6 c1 upper");
    wrReg(5'd8, 8'h00, "R6 c2 low");  wrReg(5'd9, 8'hFF, "R6 c2 high");  wrReg(5'd10, 8'h00, "R6 c2 upper");
    wrReg(5'd12, 8'h56, "R6 c3 low"); wrReg(5'd13, 8'h34, "R6 c3 high"); wrReg(5'd14, 8'h12, "R6 c3 upper");
    wrReg(5'h10, 8'h08, "R5 enable comp0");
    fetch(24'h123457, 1'b1, "R6 near miss");
    fetch(24'h123456, 1'b0, "R8 no first-byte qualifier");
    fetch(24'h123456, 1'b1, "R9 break one cycle after fetch");
    fetch(24'h123456, 1'b1, "R11 held while halted");
    wrReg(5'h10, 8'h08, "R3 release clears hits");
    wrReg(5'h10, 8'h48, "R10 enable comp0 and comp3");
    fetch(24'h123456, 1'b1, "R10 multi hit single break");
    wrReg(5'h10, 8'hE8, "R11 keep break clear hits");
    fetch(24'h00FF00, 1'b1, "R11 fetch ignored while halted");
    wrReg(5'h10, 8'h20, "R5 only comp2");
    fetch(24'h123456, 1'b1, "R5 disabled comparators");
    fetch(24'h00FF00, 1'b1, "R5 comp2 hit");
    wrReg(5'h10, 8'h10, "R7 comp1 unmasked");
    fetch(24'hABCD55, 1'b1, "R7 full compare misses");
    fetch(24'hABCD12, 1'b1, "R6 comp1 full hit");
    wrReg(5'h10, 8'h14, "R7 release with page mask");
    fetch(24'hABCD55, 1'b1, "R7 page hit");
    wrReg(5'h10, 8'h0C, "R7 mask with comp0 only");
    fetch(24'h123400, 1'b1, "R7 mask not applied to comp0");
    wrReg(5'h10, 8'h08, "R12 setup");
    step(1'b1, 5'h10, 8'h08, 24'h123456, 1'b1, "R12 match beats release");
    wrReg(5'h10, 8'h00, "R3 final release");
    fetch(24'h0, 1'b0, "R1 idle end");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule